// File: doc/BRIEF.md
# Prefetch Hint Fill Controller

The block takes software prefetch hints for a two-level data cache model and decides which levels should receive the line. Each request carries a byte address, a two-bit locality hint, a memory-type code and a legality flag. The block aligns the address down to its 32-byte line and asks both cache levels whether they already hold that line. It then issues a fill request to L1, to L2, to both or to neither. Every request ends with a single done pulse that carries a status code.

A prefetch never faults. If the address is illegal, the memory type is uncacheable, or the line already sits close enough to the core, no fill is issued and the block reports the reason. The requester sees a valid/ready handshake. The block takes one request at a time and holds ready low until that request's done pulse has gone out, including any time it spends waiting for a cache level to accept a fill.

The hint encoding is: 00 non-temporal (L1 only), 01 all-level (L1 and L2), 10 and 11 outer-level (L2 only). The memory-type code 00 means write-back cacheable. The codes 01 (write-combining), 10 (graphics aperture) and 11 (frame buffer) are uncacheable. Status codes are 00 filled, 01 already present, 10 dropped uncacheable, and 11 dropped illegal.

Top module: `pf_fill_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, and l1_fill_valid_o, l2_fill_valid_o and done_o are all 0.
- R2: A hint of 00 with the line absent from L1 issues exactly one L1 fill and no L2 fill, whether or not L2 holds the line. The status is 00.
- R3: A hint of 01 with the line absent from both levels issues one L1 fill and one L2 fill. If only L2 holds the line, it issues one L1 fill and no L2 fill. The status is 00 in both cases.
- R4: A hint of 10 or 11 with the line absent from both levels issues exactly one L2 fill and no L1 fill. The status is 00.
- R5: fill_line_o is the request address with bits [4:0] cleared. A request at any offset inside a line, including offset 31, issues at most one fill per level, and all fills go to that single line.
- R6: A legal request whose memory-type code is 01, 10 or 11 issues no fill and finishes with status 10.
- R7: A request with req_legal_i at 0 issues no fill and finishes with status 11. This check takes priority over the memory type.
- R8: If L1 holds the line, no hint issues a fill. If L2 holds the line and the hint is 10 or 11, no fill is issued. In both cases the status is 01.
- R9: From acceptance until the done pulse, req_ready_o stays 0. A fill valid stays high until its ready is seen, and the done pulse follows the last accepted fill.
- R10: Each accepted request produces exactly one done_o pulse, which lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Prefetch request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Byte address |
| req_hint_i | input | 2 | Locality hint class |
| req_mtype_i | input | 2 | Memory-type code |
| req_legal_i | input | 1 | Address is mapped and legal |
| lk_valid_o | output | 1 | Presence lookup cycle; hit inputs are sampled |
| lk_line_o | output | 32 | Line address being looked up |
| l1_hit_i | input | 1 | L1 holds lk_line_o |
| l2_hit_i | input | 1 | L2 holds lk_line_o |
| l1_fill_valid_o | output | 1 | L1 fill request |
| l1_fill_ready_i | input | 1 | L1 accepts the fill |
| l2_fill_valid_o | output | 1 | L2 fill request |
| l2_fill_ready_i | input | 1 | L2 accepts the fill |
| fill_line_o | output | 32 | Line address of the fill |
| done_o | output | 1 | Request complete, one cycle |
| status_o | output | 2 | Completion status, valid with done_o |

## Verification
A wrong hint decode or a wrong presence filter shows up within two cycles of acceptance. The cause is either a fill valid on a level that should stay quiet or a missing one, and the status code in the done pulse is wrong too. If a fill channel fails to keep its request pending, the valid drops before the cache accepts it. If a channel fails to clear, the done pulse never arrives and ready stays low. Any such fault is seen within the first stalled request. A corrupted captured line shows at fill_line_o on the first handshake.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    HINT_NTA = 2'b00,
    HINT_ALL = 2'b01,
    HINT_OUT = 2'b10,
    HINT_OUT2 = 2'b11
  } hint_e;

  typedef enum logic [1:0] {
    ST_FILLED  = 2'b00,
    ST_PRESENT = 2'b01,
    ST_DROP_UC = 2'b10,
    ST_DROP_IL = 2'b11
  } pf_status_e;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_LOOK,
    FSM_FILL,
    FSM_DONE
  } fsm_e;

  localparam logic [1:0] MTYPE_WB = 2'b00;
  localparam int unsigned NUM_LVL = 2;
endpackage

// File: rtl/pf_hint_decode.sv
module pf_hint_decode
  import pf_pkg::*;
(
  input  logic [1:0] hint_i,
  output logic       tgt_l1_o,
  output logic       tgt_l2_o
);
  always_comb begin
    tgt_l1_o = 1'b0;
    tgt_l2_o = 1'b0;
    unique case (hint_e'(hint_i))
      HINT_NTA:           tgt_l1_o = 1'b1;
      HINT_ALL: begin     tgt_l1_o = 1'b1; tgt_l2_o = 1'b1; end
      HINT_OUT, HINT_OUT2: tgt_l2_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pf_filter.sv
module pf_filter
  import pf_pkg::*;
(
  input  logic       legal_i,
  input  logic [1:0] mtype_i,
  input  logic       tgt_l1_i,
  input  logic       tgt_l2_i,
  input  logic       l1_hit_i,
  input  logic       l2_hit_i,
  output logic       need_l1_o,
  output logic       need_l2_o,
  output logic [1:0] status_o
);
  logic cacheable;
  assign cacheable = (mtype_i == MTYPE_WB);

  always_comb begin
    need_l1_o = 1'b0;
    need_l2_o = 1'b0;
    status_o  = ST_PRESENT;
    if (!legal_i) begin
      status_o = ST_DROP_IL;
    end else if (!cacheable) begin
      status_o = ST_DROP_UC;
    end else if (!l1_hit_i) begin
      // L1 hit satisfies every target: it is the closest level
      need_l1_o = tgt_l1_i;
      need_l2_o = tgt_l2_i && !l2_hit_i;
      if (need_l1_o || need_l2_o) status_o = ST_FILLED;
    end
  end

  // R7
  always_comb begin
    if (!legal_i) begin
      drop_no_fill_chk: assert (!need_l1_o && !need_l2_o);
    end
  end
endmodule

// File: rtl/pf_fill_chan.sv
module pf_fill_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic need_i,
  input  logic ready_i,
  output logic valid_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (load_i)           pend_q <= need_i;
    else if (pend_q && ready_i) pend_q <= 1'b0;
  end

  assign valid_o = pend_q;

  // R9
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> valid_o);
endmodule

// File: rtl/pf_fill_ctrl.sv
module pf_fill_ctrl
  import pf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_hint_i,
  input  logic [1:0]        req_mtype_i,
  input  logic              req_legal_i,
  output logic              lk_valid_o,
  output logic [ADDR_W-1:0] lk_line_o,
  input  logic              l1_hit_i,
  input  logic              l2_hit_i,
  output logic              l1_fill_valid_o,
  input  logic              l1_fill_ready_i,
  output logic              l2_fill_valid_o,
  input  logic              l2_fill_ready_i,
  output logic [ADDR_W-1:0] fill_line_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned LINE_W = ADDR_W - OFF_W;

  fsm_e              state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        hint_q, mtype_q, status_q;
  logic              legal_q;
  logic              accept;

  logic              tgt_l1, tgt_l2;
  logic              need_l1, need_l2;
  logic [1:0]        flt_status;
  logic [NUM_LVL-1:0] need_v, ready_v, valid_v;
  logic              chan_load;

  assign req_ready_o = (state_q == FSM_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      hint_q  <= '0;
      mtype_q <= '0;
      legal_q <= 1'b0;
    end else if (accept) begin
      line_q  <= req_addr_i[ADDR_W-1:OFF_W];
      hint_q  <= req_hint_i;
      mtype_q <= req_mtype_i;
      legal_q <= req_legal_i;
    end
  end

  pf_hint_decode i_dec (
    .hint_i   (hint_q),
    .tgt_l1_o (tgt_l1),
    .tgt_l2_o (tgt_l2)
  );

  pf_filter i_flt (
    .legal_i   (legal_q),
    .mtype_i   (mtype_q),
    .tgt_l1_i  (tgt_l1),
    .tgt_l2_i  (tgt_l2),
    .l1_hit_i  (l1_hit_i),
    .l2_hit_i  (l2_hit_i),
    .need_l1_o (need_l1),
    .need_l2_o (need_l2),
    .status_o  (flt_status)
  );

  assign chan_load = (state_q == FSM_LOOK);
  assign need_v    = {need_l2, need_l1};
  assign ready_v   = {l2_fill_ready_i, l1_fill_ready_i};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_chan
    pf_fill_chan i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (chan_load),
      .need_i  (need_v[g]),
      .ready_i (ready_v[g]),
      .valid_o (valid_v[g])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FSM_IDLE: if (accept) state_d = FSM_LOOK;
      FSM_LOOK: state_d = (need_l1 || need_l2) ? FSM_FILL : FSM_DONE;
      FSM_FILL: if ((valid_v & ~ready_v) == '0) state_d = FSM_DONE;
      FSM_DONE: state_d = FSM_IDLE;
      default:  state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FSM_IDLE;
      status_q <= ST_FILLED;
    end else begin
      state_q <= state_d;
      if (state_q == FSM_LOOK) status_q <= flt_status;
    end
  end

  assign lk_valid_o      = (state_q == FSM_LOOK);
  assign lk_line_o       = {line_q, {OFF_W{1'b0}}};
  assign fill_line_o     = {line_q, {OFF_W{1'b0}}};
  assign l1_fill_valid_o = valid_v[0];
  assign l2_fill_valid_o = valid_v[1];
  assign done_o          = (state_q == FSM_DONE);
  assign status_o        = status_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_fill_valid_o || l2_fill_valid_o) |-> !req_ready_o);
  // R2
  nta_no_l2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_fill_valid_o |-> (hint_q != HINT_NTA));
  // R4
  outer_no_l1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_fill_valid_o |-> (hint_q == HINT_NTA || hint_q == HINT_ALL));
  // R5
  line_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FSM_FILL) |=> (state_q != FSM_FILL || $stable(fill_line_o)));
  // R6
  uc_no_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_DROP_UC) |-> !(l1_fill_valid_o || l2_fill_valid_o));
endmodule

// File: tb/test_pf_fill_ctrl.sv
module test_pf_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_hint = '0;
  logic [1:0]  req_mtype = '0;
  logic        req_legal = 1'b1;
  logic        lk_valid;
  logic [31:0] lk_line;
  logic        l1_hit = 1'b0, l2_hit = 1'b0;
  logic        l1_fv, l2_fv;
  logic        l1_rdy = 1'b0, l2_rdy = 1'b0;
  logic [31:0] fill_line;
  logic        done;
  logic [1:0]  status;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  pf_fill_ctrl i_pf_fill_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_hint_i(req_hint), .req_mtype_i(req_mtype), .req_legal_i(req_legal),
    .lk_valid_o(lk_valid), .lk_line_o(lk_line),
    .l1_hit_i(l1_hit), .l2_hit_i(l2_hit),
    .l1_fill_valid_o(l1_fv), .l1_fill_ready_i(l1_rdy),
    .l2_fill_valid_o(l2_fv), .l2_fill_ready_i(l2_rdy),
    .fill_line_o(fill_line), .done_o(done), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(1'b0, "watchdog", cycles, 20000);
      finish_run();
    end
  end

  task automatic run_req(input string req, input logic [31:0] addr, input logic [1:0] hint,
                         input logic [1:0] mtype, input logic legal, input logic h1, input logic h2,
                         input int d1, input int d2, input int e1, input int e2, input logic [1:0] est);
    int n1 = 0, n2 = 0, w1 = 0, w2 = 0, cyc = 0;
    bit got = 0, busy_bad = 0, line_bad = 0;
    logic [1:0] st = '0;
    logic [31:0] eline = addr & 32'hFFFF_FFE0;
    @(negedge clk);
    chk(req_ready == 1'b1, {req, " R9 ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_hint = hint; req_mtype = mtype; req_legal = legal;
    l1_hit = h1; l2_hit = h2;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && cyc < 60) begin
      l1_rdy = l1_fv && (w1 >= d1);
      l2_rdy = l2_fv && (w2 >= d2);
      if (l1_fv) w1++;
      if (l2_fv) w2++;
      if (l1_fv && l1_rdy) begin n1++; if (fill_line !== eline) line_bad = 1; end
      if (l2_fv && l2_rdy) begin n2++; if (fill_line !== eline) line_bad = 1; end
      if (done) begin got = 1; st = status; end
      else if (req_ready) busy_bad = 1;
      cyc++;
      @(negedge clk);
    end
    l1_rdy = 1'b0; l2_rdy = 1'b0;
    chk(got, {req, " R10 done seen"}, got, 1);
    chk(done == 1'b0, {req, " R10 done single cycle"}, done, 0);
    chk(!busy_bad, {req, " R9 ready low while busy"}, busy_bad, 0);
    chk(n1 == e1, {req, " L1 fill count"}, n1, e1);
    chk(n2 == e2, {req, " L2 fill count"}, n2, e2);
    chk(st == est, {req, " status"}, st, est);
    chk(!line_bad, {req, " R5 fill line"}, fill_line, eline);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(l1_fv == 1'b0 && l2_fv == 1'b0, "R1 fill valids", {l1_fv, l2_fv}, 0);
    chk(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_nta();
    run_req("R2 nta miss", 32'h1000_0013, 2'b00, 2'b00, 1, 0, 0, 2, 0, 1, 0, 2'b00);
    run_req("R2 nta l2 hit", 32'h1000_0040, 2'b00, 2'b00, 1, 0, 1, 0, 0, 1, 0, 2'b00);
    run_req("R8 nta l1 hit", 32'h1000_0080, 2'b00, 2'b00, 1, 1, 0, 0, 0, 0, 0, 2'b01);
  endtask

  task automatic t_all();
    run_req("R3 all miss stall", 32'h2000_0104, 2'b01, 2'b00, 1, 0, 0, 1, 3, 1, 1, 2'b00);
    run_req("R3 all l2 hit", 32'h2000_0200, 2'b01, 2'b00, 1, 0, 1, 0, 0, 1, 0, 2'b00);
    run_req("R8 all l1 hit", 32'h2000_0300, 2'b01, 2'b00, 1, 1, 1, 0, 0, 0, 0, 2'b01);
  endtask

  task automatic t_outer();
    run_req("R4 t1 miss", 32'h3000_0008, 2'b10, 2'b00, 1, 0, 0, 0, 4, 0, 1, 2'b00);
    run_req("R4 t2 miss", 32'h3000_0028, 2'b11, 2'b00, 1, 0, 0, 0, 0, 0, 1, 2'b00);
    run_req("R8 t1 l2 hit", 32'h3000_0048, 2'b10, 2'b00, 1, 0, 1, 0, 0, 0, 0, 2'b01);
    run_req("R8 t2 l1 hit", 32'h3000_0068, 2'b11, 2'b00, 1, 1, 0, 0, 0, 0, 0, 2'b01);
  endtask

  task automatic t_uncacheable();
    for (int m = 1; m < 4; m++)
      run_req("R6 uncacheable", 32'h4000_0000 + 32'(m * 64), 2'b01, 2'(m), 1, 0, 0, 0, 0, 0, 0, 2'b10);
  endtask

  task automatic t_illegal();
    run_req("R7 illegal wb", 32'h5000_0010, 2'b01, 2'b00, 0, 0, 0, 0, 0, 0, 0, 2'b11);
    run_req("R7 illegal over uc", 32'h5000_0030, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 0, 2'b11);
  endtask

  task automatic t_unaligned();
    run_req("R5 offset 31", 32'h6000_003F, 2'b01, 2'b00, 1, 0, 0, 2, 1, 1, 1, 2'b00);
    run_req("R5 offset 1", 32'h6000_0041, 2'b00, 2'b00, 1, 0, 0, 0, 0, 1, 0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nta();
    t_all();
    t_outer();
    t_uncacheable();
    t_illegal();
    t_unaligned();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule